// File: doc/BRIEF.md
# I2C Slave Byte Engine with Clock Stretching

This block is an I2C slave transceiver clocked by a fast system clock. It oversamples SCL and SDA and drives each line only through a pull-low enable, so it sits on an open-drain bus. A host moves bytes through it. On receive, the host collects bytes from a holding register. On transmit, the host loads bytes into a holding register. The block generates the acknowledge when it receives and checks it when it transmits. It raises single-cycle per-byte strobes and keeps sticky flags for a master no-acknowledge and for bus STOP.

Each line passes through a synchronizer and a three-tap majority vote. START, STOP and clock edges are found on the filtered values. After a START, the first byte is compared with the programmed 7-bit address. Bit 0 of that byte selects the direction: 0 means the master writes, 1 means the master reads.

Both directions are double buffered: a shift register and a holding register. When the host falls behind, the block holds SCL low until the host catches up. A receive byte cannot move into a holding register that is still full, and a transmit byte cannot be loaded while the holding register is empty.

Top module: `i2c_byte_slave`

## Requirements
- R1: Data bits are sampled on SCL rising edges, most significant bit first. At the falling edge of the ninth clock, a received byte moves to `rx_data_o`. At that point `rx_valid_o` sets and `rx_irq_o` pulses for one cycle. `rx_read_i` clears `rx_valid_o`.
- R2: After a START, a first byte whose upper seven bits equal `own_addr_i` is acknowledged, and its bit 0 selects master-write (0) or master-read (1). On a mismatch, SDA stays released for that byte and all later bytes until the next START.
- R3: In master-write mode, the slave drives SDA low on the ninth clock when `nak_reply_i` is low. When it is high, the slave leaves SDA released and ignores further bytes until the next START.
- R4: If `rx_valid_o` is still set at the ninth falling edge, SCL is held low and `rx_data_o` keeps the older byte. After `rx_read_i`, the new byte is loaded and SCL is released.
- R5: In master-read mode, at the ninth falling edge the slave loads the held transmit byte into the shift register. At that edge `tx_full_o` clears and `tx_irq_o` pulses. The byte is then sent MSB first.
- R6: If the transmit holding register is empty at that edge, SCL is held low. After `tx_write_i`, the byte is loaded, `tx_irq_o` pulses and SCL is released.
- R7: SDA high on the ninth clock after a transmitted byte sets `nak_flag_o`. The flag stays set until `nak_clr_i` is pulsed. `nak_irq_o` is the flag gated by `nak_irq_en_i`. Transmission ends after a no-acknowledge.
- R8: A STOP (SDA rising while SCL is high) sets `stop_flag_o`, which stays set until `stop_clr_i` is pulsed.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: A START in the middle of a transfer drops the partial byte, releases any SCL hold and restarts address reception. The holding registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_drive_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low_o | output | 1 | Pull SDA low |
| own_addr_i | input | 7 | Slave address |
| nak_reply_i | input | 1 | Answer received bytes with NAK |
| rx_data_o | output | 8 | Receive holding register |
| rx_valid_o | output | 1 | Receive holding register full |
| rx_read_i | input | 1 | Host read strobe, empties the holding register |
| rx_irq_o | output | 1 | Byte received strobe |
| tx_data_i | input | 8 | Byte to transmit |
| tx_write_i | input | 1 | Host write strobe for the transmit holding register |
| tx_full_o | output | 1 | Transmit holding register occupied |
| tx_irq_o | output | 1 | Transmit byte loaded strobe |
| nak_flag_o | output | 1 | Master no-acknowledge seen |
| nak_irq_en_i | input | 1 | Enable for the NAK interrupt |
| nak_irq_o | output | 1 | NAK interrupt |
| nak_clr_i | input | 1 | Clear `nak_flag_o` |
| stop_flag_o | output | 1 | STOP seen |
| stop_clr_i | input | 1 | Clear `stop_flag_o` |

## Verification
Some properties are checked on every cycle: SDA drive changes only while the filtered SCL is low, and a START always frees SCL. Every clock stretch must start from a full receive holding register or an empty transmit one, the receive strobe never fires without valid data, and both status flags stay set until cleared. Other behaviour only the bench's bus scenarios can show. These are:
- the byte values across the wired-AND bus;
- the acknowledge levels the master samples;
- how long SCL is actually held, and that it is released after the host acts;
- that a mismatched address or a NAK reply silences the slave;
- that a repeated START discards a partial byte.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_RX_WAIT,
    ST_TX, ST_TX_ACK, ST_TX_WAIT
  } slv_state_e;

  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(VOTE_TAPS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_TAPS-1:0]   hist_q;
  logic [CW-1:0]          ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTE_TAPS; i++) ones = ones + CW'(hist_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q <= {hist_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      line_o <= (ones > CW'(VOTE_TAPS / 2));
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
  import i2c_slv_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_f_i,
  input  logic    sda_f_i,
  output bus_ev_t ev_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
    end
  end

  always_comb begin
    ev_o.scl      = scl_f_i;
    ev_o.sda      = sda_f_i;
    ev_o.scl_rise = scl_f_i & ~scl_q;
    ev_o.scl_fall = ~scl_f_i & scl_q;
    // conditions only count when SCL is steadily high
    ev_o.start    = scl_q & scl_f_i & sda_q & ~sda_f_i;
    ev_o.stop     = scl_q & scl_f_i & ~sda_q & sda_f_i;
  end
endmodule

// File: rtl/i2c_byte_slave.sv
module i2c_byte_slave
  import i2c_slv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low_o,
  output logic              sda_drive_low_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              nak_reply_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_read_i,
  output logic              rx_irq_o,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_write_i,
  output logic              tx_full_o,
  output logic              tx_irq_o,
  output logic              nak_flag_o,
  input  logic              nak_irq_en_i,
  output logic              nak_irq_o,
  input  logic              nak_clr_i,
  output logic              stop_flag_o,
  input  logic              stop_clr_i
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic [1:0] raw_lines, filt_lines;
  logic       scl_filt, start_det;
  bus_ev_t    ev;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  i2c_bus_events u_ev (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_f_i(filt_lines[0]),
    .sda_f_i(filt_lines[1]),
    .ev_o   (ev)
  );

  assign scl_filt  = ev.scl;
  assign start_det = ev.start;

  slv_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, rx_hold_q, tx_hold_q;
  logic              ack_drv_q, nakd_q, rw_q, mnak_q;
  logic              rx_valid_q, tx_full_q, rx_irq_q, tx_irq_q, nak_flag_q, stop_flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      sh_q        <= '0;
      rx_hold_q   <= '0;
      tx_hold_q   <= '0;
      ack_drv_q   <= 1'b0;
      nakd_q      <= 1'b0;
      rw_q        <= 1'b0;
      mnak_q      <= 1'b0;
      rx_valid_q  <= 1'b0;
      tx_full_q   <= 1'b0;
      rx_irq_q    <= 1'b0;
      tx_irq_q    <= 1'b0;
      nak_flag_q  <= 1'b0;
      stop_flag_q <= 1'b0;
    end else begin
      rx_irq_q <= 1'b0;
      tx_irq_q <= 1'b0;
      if (rx_read_i)  rx_valid_q  <= 1'b0;
      if (nak_clr_i)  nak_flag_q  <= 1'b0;
      if (stop_clr_i) stop_flag_q <= 1'b0;

      if (ev.stop) begin
        stop_flag_q <= 1'b1;
        st_q        <= ST_IDLE;
      end else if (ev.start) begin
        st_q  <= ST_ADDR;
        cnt_q <= '0;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (ev.scl_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], ev.sda};
              cnt_q <= cnt_q + 1'b1;
            end else if (ev.scl_fall && cnt_q == LAST_BIT) begin
              if (sh_q[BYTE_W-1 -: ADDR_W] == own_addr_i) begin
                st_q      <= ST_ADDR_ACK;
                ack_drv_q <= 1'b1;
                rw_q      <= sh_q[0];
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_RX: begin
            if (ev.scl_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], ev.sda};
              cnt_q <= cnt_q + 1'b1;
            end else if (ev.scl_fall && cnt_q == LAST_BIT) begin
              st_q      <= ST_RX_ACK;
              ack_drv_q <= ~nak_reply_i;
              nakd_q    <= nak_reply_i;
            end
          end
          ST_TX: begin
            if (ev.scl_rise) cnt_q <= cnt_q + 1'b1;
            else if (ev.scl_fall) begin
              if (cnt_q == LAST_BIT) st_q <= ST_TX_ACK;
              else sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
            end
          end
          ST_TX_ACK: begin
            if (ev.scl_rise) begin
              mnak_q <= ev.sda;
              if (ev.sda) nak_flag_q <= 1'b1;
            end
          end
          default: ;
        endcase

        // ninth-clock falling edge and wait-state exits
        if ((st_q == ST_RX_ACK && ev.scl_fall) || st_q == ST_RX_WAIT) begin
          if (!rx_valid_q) begin
            rx_hold_q  <= sh_q;
            rx_valid_q <= 1'b1;
            rx_irq_q   <= 1'b1;
            cnt_q      <= '0;
            st_q       <= nakd_q ? ST_IDLE : ST_RX;
          end else begin
            st_q <= ST_RX_WAIT;
          end
        end
        if (st_q == ST_ADDR_ACK && ev.scl_fall && !rw_q) begin
          st_q  <= ST_RX;
          cnt_q <= '0;
        end
        if ((st_q == ST_ADDR_ACK && ev.scl_fall && rw_q) ||
            (st_q == ST_TX_ACK && ev.scl_fall && !mnak_q) || st_q == ST_TX_WAIT) begin
          if (tx_full_q) begin
            sh_q      <= tx_hold_q;
            tx_full_q <= 1'b0;
            tx_irq_q  <= 1'b1;
            cnt_q     <= '0;
            st_q      <= ST_TX;
          end else begin
            st_q <= ST_TX_WAIT;
          end
        end
        if (st_q == ST_TX_ACK && ev.scl_fall && mnak_q) st_q <= ST_IDLE;
      end

      if (tx_write_i) begin
        tx_hold_q <= tx_data_i;
        tx_full_q <= 1'b1;
      end
    end
  end

  assign scl_drive_low_o = (st_q == ST_RX_WAIT) || (st_q == ST_TX_WAIT);
  assign sda_drive_low_o = ((st_q == ST_TX) && !sh_q[BYTE_W-1]) ||
                           ((st_q == ST_ADDR_ACK || st_q == ST_RX_ACK) && ack_drv_q);
  assign rx_data_o   = rx_hold_q;
  assign rx_valid_o  = rx_valid_q;
  assign rx_irq_o    = rx_irq_q;
  assign tx_full_o   = tx_full_q;
  assign tx_irq_o    = tx_irq_q;
  assign nak_flag_o  = nak_flag_q;
  assign nak_irq_o   = nak_flag_q & nak_irq_en_i;
  assign stop_flag_o = stop_flag_q;
endmodule

// File: rtl/i2c_byte_slave_chk.sv
module i2c_byte_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_filt,
  input logic start_det,
  input logic scl_drive_low_o,
  input logic sda_drive_low_o,
  input logic rx_valid_o,
  input logic rx_irq_o,
  input logic tx_full_o,
  input logic nak_flag_o,
  input logic nak_clr_i,
  input logic stop_flag_o,
  input logic stop_clr_i
);
  assert_sda_moves_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_drive_low_o) |-> !scl_filt);

  assert_start_frees_scl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !scl_drive_low_o);

  // covers R4 (receive full) and R6 (transmit empty)
  assert_hold_has_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_drive_low_o) |-> $past(rx_valid_o || !tx_full_o));

  assert_rx_irq_with_data_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> rx_valid_o);

  assert_nak_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nak_flag_o && !nak_clr_i |=> nak_flag_o);

  assert_stop_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_flag_o && !stop_clr_i |=> stop_flag_o);
endmodule

bind i2c_byte_slave i2c_byte_slave_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .scl_filt       (scl_filt),
  .start_det      (start_det),
  .scl_drive_low_o(scl_drive_low_o),
  .sda_drive_low_o(sda_drive_low_o),
  .rx_valid_o     (rx_valid_o),
  .rx_irq_o       (rx_irq_o),
  .tx_full_o      (tx_full_o),
  .nak_flag_o     (nak_flag_o),
  .nak_clr_i      (nak_clr_i),
  .stop_flag_o    (stop_flag_o),
  .stop_clr_i     (stop_clr_i)
);

// File: tb/i2c_byte_slave_tb.sv
`timescale 1ns/1ps
module i2c_byte_slave_tb;
  localparam int Q = 20;
  localparam logic [6:0] MY_ADDR = 7'h50;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl, sda;
  logic scl_drive_low_o, sda_drive_low_o;
  logic nak_reply_i = 1'b0, rx_read_i = 1'b0, tx_write_i = 1'b0;
  logic nak_irq_en_i = 1'b1, nak_clr_i = 1'b0, stop_clr_i = 1'b0;
  logic [7:0] tx_data_i = '0, rx_data_o;
  logic rx_valid_o, rx_irq_o, tx_full_o, tx_irq_o, nak_flag_o, nak_irq_o, stop_flag_o;

  assign scl = ~(m_scl_low | scl_drive_low_o);
  assign sda = ~(m_sda_low | sda_drive_low_o);

  i2c_byte_slave u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda),
    .scl_drive_low_o(scl_drive_low_o), .sda_drive_low_o(sda_drive_low_o),
    .own_addr_i(MY_ADDR), .nak_reply_i(nak_reply_i),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_read_i(rx_read_i), .rx_irq_o(rx_irq_o),
    .tx_data_i(tx_data_i), .tx_write_i(tx_write_i), .tx_full_o(tx_full_o), .tx_irq_o(tx_irq_o),
    .nak_flag_o(nak_flag_o), .nak_irq_en_i(nak_irq_en_i), .nak_irq_o(nak_irq_o),
    .nak_clr_i(nak_clr_i), .stop_flag_o(stop_flag_o), .stop_clr_i(stop_clr_i)
  );

  int n_cmp = 0, n_bad = 0;
  int rx_irqs = 0, tx_irqs = 0, sda_viol = 0, cyc = 0;
  logic scl_prev = 1'b1, sdrv_prev = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rx_irq_o) rx_irqs <= rx_irqs + 1;
    if (tx_irq_o) tx_irqs <= tx_irqs + 1;
    if (rst_ni && sda_drive_low_o != sdrv_prev && scl_prev) sda_viol <= sda_viol + 1;
    scl_prev  <= scl;
    sdrv_prev <= sda_drive_low_o;
  end

  always @(negedge clk) if (cyc == 150000) begin
    n_bad++;
    $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic bit [7:0] addr_byte(input bit [6:0] a, input bit rd);
    return {a, rd};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    int t = 0;
    while (!scl && t < 5000) begin @(negedge clk); t++; end
    if (!scl) begin n_bad++; $display("FAIL bus: act=scl_low exp=scl_released"); end
  endtask

  task automatic clock_bit(input bit lvl, output bit r);
    m_sda_low = !lvl; wt(Q);
    m_scl_low = 1'b0; wait_scl_high(); wt(Q);
    r = sda; wt(Q);
    m_scl_low = 1'b1; wt(Q);
  endtask

  task automatic start_cond();
    m_sda_low = 1'b1; wt(Q);
    m_scl_low = 1'b1; wt(Q);
  endtask

  task automatic restart_cond();
    m_sda_low = 1'b0; wt(Q);
    m_scl_low = 1'b0; wait_scl_high(); wt(Q);
    m_sda_low = 1'b1; wt(Q);
    m_scl_low = 1'b1; wt(Q);
  endtask

  task automatic stop_cond();
    m_sda_low = 1'b1; wt(Q);
    m_scl_low = 1'b0; wait_scl_high(); wt(Q);
    m_sda_low = 1'b0; wt(2*Q);
  endtask

  task automatic send_byte(input bit [7:0] b, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
    clock_bit(1'b1, ack);
  endtask

  task automatic recv_byte(input bit master_ack, output bit [7:0] b);
    bit r;
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, r); b[i] = r; end
    clock_bit(!master_ack, r);
  endtask

  task automatic host_read();
    @(negedge clk) rx_read_i = 1'b1;
    @(negedge clk) rx_read_i = 1'b0;
  endtask

  task automatic host_write(input bit [7:0] d);
    @(negedge clk) begin tx_data_i = d; tx_write_i = 1'b1; end
    @(negedge clk) tx_write_i = 1'b0;
  endtask

  task automatic pulse_stop_clr();
    @(negedge clk) stop_clr_i = 1'b1;
    @(negedge clk) stop_clr_i = 1'b0;
  endtask

  initial begin
    bit ack, r;
    bit [7:0] b, got, tx_q[4];
    int base;
    void'($urandom(32'd4242));
    wt(5);
    rst_ni = 1'b1;
    wt(10);
    chk(!scl_drive_low_o && !sda_drive_low_o, "R9 reset drives", {scl_drive_low_o, sda_drive_low_o}, 0);
    chk(!rx_valid_o && !tx_full_o && !nak_flag_o && !stop_flag_o, "R1 reset flags",
        {rx_valid_o, tx_full_o, nak_flag_o, stop_flag_o}, 0);

    // R1/R3 random receive stream
    start_cond();
    send_byte(addr_byte(MY_ADDR, 1'b0), ack);
    chk(ack == 1'b0, "R2 address ack", ack, 0);
    for (int n = 0; n < 8; n++) begin
      b = 8'($urandom);
      if (n == 0) b = 8'h80;
      if (n == 1) b = 8'h01;
      base = rx_irqs;
      send_byte(b, ack);
      chk(ack == 1'b0, "R3 data ack", ack, 0);
      chk(rx_valid_o && rx_data_o == b, "R1 rx byte", rx_data_o, b);
      chk(rx_irqs == base + 1, "R1 rx strobe", rx_irqs, base + 1);
      host_read();
      wt(2);
      chk(!rx_valid_o, "R1 read clears", rx_valid_o, 0);
    end
    stop_cond();
    chk(stop_flag_o, "R8 stop sets", stop_flag_o, 1);
    wt(50);
    chk(stop_flag_o, "R8 stop sticky", stop_flag_o, 1);
    pulse_stop_clr();
    wt(2);
    chk(!stop_flag_o, "R8 stop clear", stop_flag_o, 0);

    // R2 address mismatch
    base = rx_irqs;
    start_cond();
    send_byte(addr_byte(7'h23, 1'b0), ack);
    chk(ack == 1'b1, "R2 mismatch no ack", ack, 1);
    send_byte(8'h5A, ack);
    chk(ack == 1'b1 && !rx_valid_o && rx_irqs == base, "R2 mismatch ignored",
        {ack, rx_valid_o}, 2'b10);
    stop_cond();

    // R3 NAK reply policy
    nak_reply_i = 1'b1;
    start_cond();
    send_byte(addr_byte(MY_ADDR, 1'b0), ack);
    chk(ack == 1'b0, "R2 address ack nak mode", ack, 0);
    send_byte(8'hC3, ack);
    chk(ack == 1'b1, "R3 nak reply", ack, 1);
    chk(rx_valid_o && rx_data_o == 8'hC3, "R3 nak byte kept", rx_data_o, 8'hC3);
    host_read();
    send_byte(8'h3C, ack);
    chk(ack == 1'b1 && !rx_valid_o, "R3 ignored after nak", {ack, rx_valid_o}, 2'b10);
    stop_cond();
    nak_reply_i = 1'b0;

    // R4 receive stretch
    start_cond();
    send_byte(addr_byte(MY_ADDR, 1'b0), ack);
    send_byte(8'hA5, ack);
    send_byte(8'h96, ack);
    chk(ack == 1'b0, "R4 second ack", ack, 0);
    m_sda_low = 1'b1; wt(Q);
    m_scl_low = 1'b0; wt(100);
    chk(scl == 1'b0, "R4 scl held", scl, 0);
    chk(rx_data_o == 8'hA5, "R4 old byte kept", rx_data_o, 8'hA5);
    host_read();
    wt(3);
    chk(rx_valid_o && rx_data_o == 8'h96, "R4 new byte loaded", rx_data_o, 8'h96);
    chk(scl == 1'b1, "R4 scl released", scl, 1);
    wait_scl_high(); wt(Q);
    m_sda_low = 1'b0; wt(2*Q);
    chk(stop_flag_o, "R8 stop after stretch", stop_flag_o, 1);
    host_read();
    pulse_stop_clr();

    // R5/R7 transmit with prefilled holding register
    for (int k = 0; k < 4; k++) tx_q[k] = 8'($urandom);
    tx_q[0] = 8'h7E;
    host_write(tx_q[0]);
    chk(tx_full_o, "R5 holding full", tx_full_o, 1);
    base = tx_irqs;
    start_cond();
    send_byte(addr_byte(MY_ADDR, 1'b1), ack);
    chk(ack == 1'b0, "R2 read address ack", ack, 0);
    chk(!tx_full_o && tx_irqs == base + 1, "R5 load at ninth fall", {tx_full_o, 8'(tx_irqs - base)}, 1);
    for (int k = 0; k < 4; k++) begin
      if (k < 3) host_write(tx_q[k+1]);
      recv_byte(k < 3, got);
      chk(got == tx_q[k], "R5 tx byte", got, tx_q[k]);
    end
    chk(tx_irqs == base + 4, "R5 tx strobes", tx_irqs - base, 4);
    chk(nak_flag_o && nak_irq_o, "R7 nak flag", {nak_flag_o, nak_irq_o}, 2'b11);
    stop_cond();
    nak_irq_en_i = 1'b0;
    wt(2);
    chk(nak_flag_o && !nak_irq_o, "R7 irq gated", {nak_flag_o, nak_irq_o}, 2'b10);
    nak_irq_en_i = 1'b1;
    @(negedge clk) nak_clr_i = 1'b1;
    @(negedge clk) nak_clr_i = 1'b0;
    wt(2);
    chk(!nak_flag_o, "R7 nak clear", nak_flag_o, 0);
    pulse_stop_clr();

    // R6 transmit stretch with empty holding register
    base = tx_irqs;
    start_cond();
    send_byte(addr_byte(MY_ADDR, 1'b1), ack);
    m_sda_low = 1'b0; wt(Q);
    m_scl_low = 1'b0; wt(100);
    chk(scl == 1'b0, "R6 scl held", scl, 0);
    chk(tx_irqs == base, "R6 no strobe while empty", tx_irqs - base, 0);
    host_write(8'h2D);
    wait_scl_high(); wt(Q);
    got[7] = sda; wt(Q);
    m_scl_low = 1'b1; wt(Q);
    for (int i = 6; i >= 0; i--) begin clock_bit(1'b1, r); got[i] = r; end
    clock_bit(1'b1, r);
    chk(got == 8'h2D, "R6 byte after release", got, 8'h2D);
    chk(tx_irqs == base + 1, "R6 strobe after write", tx_irqs - base, 1);
    stop_cond();
    @(negedge clk) nak_clr_i = 1'b1;
    @(negedge clk) nak_clr_i = 1'b0;

    // R10 repeated start aborts partial byte
    base = rx_irqs;
    start_cond();
    send_byte(addr_byte(MY_ADDR, 1'b0), ack);
    for (int i = 0; i < 3; i++) clock_bit(1'b1, r);
    restart_cond();
    chk(!rx_valid_o && rx_irqs == base, "R10 partial dropped", rx_irqs - base, 0);
    send_byte(addr_byte(MY_ADDR, 1'b0), ack);
    chk(ack == 1'b0, "R10 readdress ack", ack, 0);
    send_byte(8'hE1, ack);
    chk(rx_valid_o && rx_data_o == 8'hE1 && rx_irqs == base + 1, "R10 clean restart", rx_data_o, 8'hE1);
    stop_cond();

    chk(sda_viol == 0, "R9 sda only while scl low", sda_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule